// File: doc/BRIEF.md
# Event-Action PWM Generator with Staged Register Updates

This block is one PWM generator that drives a pair of outputs from a single counter. The counter is 16 bits wide and runs in one of two modes. In falling mode it counts down from a period limit to zero and then reloads. In triangle mode it climbs from zero to the limit and falls back to zero.

Two compare thresholds watch the counter. Six counter events are defined: counter at zero, counter at limit, threshold A reached while rising, threshold A reached while falling, threshold B reached while rising, and threshold B reached while falling. Each output has its own action table. The table gives a 2-bit code for each event, which tells the output to hold, toggle, go low or go high.

Software writes through a simple register port. The period limit, the two thresholds and the two action tables are staged. Each class has its own commit mode: immediate, at the next counter zero, or at the first counter zero after an explicit update request. Several generators can share one update request and one sync strobe, so that they change values together and restart together.

Top module: `pwm_event_gen`

## Requirements
- R1: When the mode bit `ctl[0]` is 0 (falling mode), the counter steps down by one each clock. From zero, or from any value above the limit, it loads the limit. With a limit of zero it stays at zero.
- R2: When `ctl[0]` is 1 (triangle mode), the counter rises by one up to the limit. On reaching the limit it falls by one back to zero, and from zero it rises again. With a limit of zero it stays at zero.
- R3: Each action code is 2 bits: 0 holds, 1 toggles, 2 drives low, 3 drives high. An output changes on the clock edge that ends the cycle in which the counter shows the event value. In any cycle with no event, both outputs keep their values.
- R4: The action table (address 4 for output A, address 5 for output B) has these fields: bits [1:0] zero, [3:2] limit, [5:4] A rising, [7:6] A falling, [9:8] B rising, [11:10] B falling. A compare match counts as rising only in triangle mode while the counter is on its rising leg. In falling mode only the zero, limit and falling-compare fields are used.
- R5: On the same cycle, a zero event outranks a limit event, and both outrank any compare event. Only the action of the highest-ranked event is applied.
- R6: When threshold A and threshold B match on the same cycle, only the threshold A action is applied.
- R7: The commit-mode code 0 means immediate: a written value is used from the next clock.
- R8: Commit-mode code 1 means local: a written value is held pending and becomes active on the clock edge that ends a cycle in which the counter is zero. A reload taken on that same edge already uses the new limit.
- R9: Commit-mode codes 2 and 3 mean global: pending values become active only at a counter-zero edge that comes after an `upd_req` pulse. `upd_busy` rises on the clock after the request and clears when that commit happens.
- R10: Control register `ctl` (address 0) takes effect at once. Its field [2:1] sets the commit mode of the limit (address 1), field [4:3] sets the mode of both thresholds (addresses 2 and 3), and field [6:5] sets the mode of both action tables.
- R11: A pulse on `sync_in` sets the counter to zero on the next clock and puts the triangle counter on its rising leg.
- R12: After reset the counter, both outputs and `upd_busy` are 0, and every register and pending value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 ctl, 1 limit, 2 threshold A, 3 threshold B, 4 table A, 5 table B) |
| wr_data | input | 16 | Write data |
| sync_in | input | 1 | Counter restart strobe |
| upd_req | input | 1 | Global update request strobe |
| count | output | 16 | Current counter value |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| upd_busy | output | 1 | Global request armed and not yet committed |

## Verification
The bench builds the block with its default 16-bit counter. It keeps every limit and threshold below 32, so a run of a few thousand cycles passes through many periods and hits all six events, including every collision case. With limits this small, a zero limit, thresholds that equal zero or the limit, and writes that land on the commit edge all occur often. Random mixes of commit modes, together with sync and update strobes, exercise the staging paths against each other.

// File: rtl/pwm_event_gen.sv
module pwm_event_gen #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          sync_in,
  input  logic          upd_req,
  output logic [CW-1:0] count,
  output logic          pwm_a,
  output logic          pwm_b,
  output logic          upd_busy
);
  localparam int NREG = 5;

  logic [6:0] ctl;
  logic       dir_up;
  logic [NREG-1:0] cm;

  wire updown  = ctl[0];
  wire at_zero = (count == '0);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [CW-1:0] a, p;
    wire [1:0] md = (i == 0) ? ctl[2:1] : (i < 3) ? ctl[4:3] : ctl[6:5];
    wire we = wr_en && (wr_addr == 3'(i + 1));
    assign cm[i] = at_zero && (md == 2'd1 || (md[1] && upd_busy));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a <= '0;
        p <= '0;
      end else begin
        if (we) p <= wr_data;
        if (we && md == 2'd0) a <= wr_data;
        else if (cm[i]) a <= p;
      end
    end
  end

  wire [CW-1:0] lim    = g_reg[0].a;
  wire [CW-1:0] lim_nx = cm[0] ? g_reg[0].p : g_reg[0].a;
  wire at_lim = (count == lim);
  wire hit_a  = (count == g_reg[1].a);
  wire hit_b  = (count == g_reg[2].a);
  wire rising = updown && dir_up;

  function automatic logic [1:0] pick(input logic [CW-1:0] t);
    if (at_zero) return t[1:0];
    if (at_lim)  return t[3:2];
    if (hit_a)   return rising ? t[5:4] : t[7:6];
    if (hit_b)   return rising ? t[9:8] : t[11:10];
    return 2'd0;
  endfunction

  function automatic logic drive(input logic cur, input logic [1:0] c);
    case (c)
      2'd1:    return ~cur;
      2'd2:    return 1'b0;
      2'd3:    return 1'b1;
      default: return cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl <= '0;
    else if (wr_en && wr_addr == 3'd0) ctl <= wr_data[6:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      dir_up <= 1'b1;
    end else if (sync_in) begin
      count  <= '0;
      dir_up <= 1'b1;
    end else if (!updown) begin
      count <= (at_zero || count > lim_nx) ? lim_nx : count - 1'b1;
    end else if (lim_nx == '0) begin
      count  <= '0;
      dir_up <= 1'b1;
    end else if (dir_up) begin
      if (count >= lim_nx) begin
        count  <= lim_nx - 1'b1;
        dir_up <= 1'b0;
      end else count <= count + 1'b1;
    end else if (at_zero) begin
      count  <= CW'(1);
      dir_up <= 1'b1;
    end else count <= count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_a    <= 1'b0;
      pwm_b    <= 1'b0;
      upd_busy <= 1'b0;
    end else begin
      pwm_a    <= drive(pwm_a, pick(g_reg[3].a));
      pwm_b    <= drive(pwm_b, pick(g_reg[4].a));
      upd_busy <= upd_req || (upd_busy && !at_zero);
    end
  end
endmodule

module pwm_event_gen_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_in,
  input logic          upd_req,
  input logic [CW-1:0] count,
  input logic          pwm_a,
  input logic          pwm_b,
  input logic          upd_busy,
  input logic          updown,
  input logic [CW-1:0] lim,
  input logic [CW-1:0] thr_a,
  input logic [CW-1:0] thr_b
);
  assert_sync_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sync_in |=> count == '0);

  assert_req_arms_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |=> upd_busy);

  assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_busy && count != '0) |=> upd_busy);

  assert_busy_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_busy && count == '0 && !upd_req) |=> !upd_busy);

  assert_down_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_in && !updown && count != '0 && count <= lim) |=> count == CW'($past(count) - 1'b1));

  assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(count == '0 || count == lim || count == thr_a || count == thr_b)
      |=> ($stable(pwm_a) && $stable(pwm_b)));
endmodule

bind pwm_event_gen pwm_event_gen_chk #(.CW(CW)) chk (
  .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .upd_req(upd_req),
  .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b), .upd_busy(upd_busy),
  .updown(ctl[0]), .lim(g_reg[0].a), .thr_a(g_reg[1].a), .thr_b(g_reg[2].a)
);

// File: tb/pwm_event_gen_test.sv
`timescale 1ns/1ps
module pwm_event_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic sync_in = 1'b0;
  logic upd_req = 1'b0;
  logic [15:0] count;
  logic pwm_a, pwm_b, upd_busy;

  int n_chk = 0, n_bad = 0;
  string tag = "R12";

  always #2.5 clk = ~clk;

  pwm_event_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_in(sync_in), .upd_req(upd_req), .count(count),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .upd_busy(upd_busy)
  );

  // behavioural reference
  int m_cnt, m_up, m_busy, m_pa, m_pb, m_ctl;
  int m_act[5], m_pen[5];

  function automatic int code_of(int tbl, int c, int up, int lim, int ta, int tb);
    if (c == 0) return tbl & 3;
    if (c == lim) return (tbl >> 2) & 3;
    if (c == ta) return up ? (tbl >> 4) & 3 : (tbl >> 6) & 3;
    if (c == tb) return up ? (tbl >> 8) & 3 : (tbl >> 10) & 3;
    return 0;
  endfunction

  function automatic int apply(int cur, int c);
    if (c == 1) return 1 - cur;
    if (c == 2) return 0;
    if (c == 3) return 1;
    return cur;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_up = 1; m_busy = 0; m_pa = 0; m_pb = 0; m_ctl = 0;
      for (int i = 0; i < 5; i++) begin m_act[i] = 0; m_pen[i] = 0; end
    end else begin
      int md[5];
      int cmt[5];
      int nact[5];
      int up, z, ld;
      md[0] = (m_ctl >> 1) & 3;
      md[1] = (m_ctl >> 3) & 3; md[2] = md[1];
      md[3] = (m_ctl >> 5) & 3; md[4] = md[3];
      z = (m_cnt == 0);
      up = (m_ctl & 1) && m_up;
      m_pa = apply(m_pa, code_of(m_act[3], m_cnt, up, m_act[0], m_act[1], m_act[2]));
      m_pb = apply(m_pb, code_of(m_act[4], m_cnt, up, m_act[0], m_act[1], m_act[2]));
      for (int i = 0; i < 5; i++) cmt[i] = z && (md[i] == 1 || (md[i] >= 2 && m_busy));
      ld = cmt[0] ? m_pen[0] : m_act[0];
      if (sync_in) begin m_cnt = 0; m_up = 1; end
      else if ((m_ctl & 1) == 0) m_cnt = (z || m_cnt > ld) ? ld : m_cnt - 1;
      else if (ld == 0) begin m_cnt = 0; m_up = 1; end
      else if (m_up) begin
        if (m_cnt >= ld) begin m_cnt = ld - 1; m_up = 0; end else m_cnt++;
      end else if (z) begin m_cnt = 1; m_up = 1; end
      else m_cnt--;
      m_busy = upd_req || (m_busy && !z);
      for (int i = 0; i < 5; i++) begin
        nact[i] = cmt[i] ? m_pen[i] : m_act[i];
        if (wr_en && wr_addr == i + 1) begin
          m_pen[i] = wr_data;
          if (md[i] == 0) nact[i] = wr_data;
        end
        m_act[i] = nact[i];
      end
      if (wr_en && wr_addr == 0) m_ctl = wr_data & 7'h7f;
    end
  end

  task automatic check(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check(tag, {count, pwm_a, pwm_b, upd_busy}, {m_cnt[15:0], m_pa[0], m_pb[0], m_busy[0]});
    wr_en = 1'b0; sync_in = 1'b0; upd_req = 1'b0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    step();
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    check("R12", {count, pwm_a, pwm_b, upd_busy}, 0);
    run(4);

    // R1 R3 falling mode, immediate commits
    tag = "R1";
    wr(1, 9); wr(2, 4);
    wr(4, 16'h003 | (2 << 6));
    wr(5, 1 << 2);
    run(40);

    // R2 R4 triangle mode, rising vs falling compare actions
    tag = "R2";
    wr(0, 1); wr(3, 6);
    wr(4, (3 << 4) | (2 << 6));
    wr(5, (1 << 8) | (3 << 10));
    run(60);
    tag = "R4";
    wr(0, 0); run(40);

    // R5 zero and limit outrank compares; zero outranks limit
    tag = "R5";
    wr(0, 1); wr(2, 0); wr(3, 9);
    wr(4, 2 | (3 << 6) | (3 << 4));
    wr(5, (1 << 2) | (2 << 8) | (3 << 10));
    run(50);
    wr(1, 0); run(10);
    wr(1, 9); run(20);

    // R6 threshold A outranks threshold B
    tag = "R6";
    wr(2, 5); wr(3, 5);
    wr(4, (3 << 4) | (3 << 6) | (2 << 8) | (2 << 10) | 2);
    wr(5, (2 << 4) | (2 << 6) | (3 << 8) | (3 << 10) | 3);
    run(50);

    // R7 immediate change mid period
    tag = "R7";
    wr(1, 14); run(7); wr(2, 11); run(30);

    // R8 local commits at counter zero
    tag = "R8";
    wr(0, 1 | (1 << 1) | (1 << 3) | (1 << 5));
    run(5); wr(1, 6); wr(2, 2); wr(4, 16'h0F0);
    run(60);
    wr(0, (1 << 1) | (1 << 3) | (1 << 5));
    run(3); wr(1, 11); run(40);

    // R9 global commit after request
    tag = "R9";
    wr(0, 1 | (2 << 1) | (2 << 3) | (2 << 5));
    wr(1, 20); wr(3, 3); run(40);
    upd_req = 1'b1; step();
    check("R9", upd_busy, 1);
    run(60);
    check("R9", upd_busy, 0);

    // R10 per-class modes
    tag = "R10";
    wr(0, 1 | (0 << 1) | (1 << 3) | (3 << 5));
    wr(1, 8); wr(2, 3); wr(5, 16'hC30); run(30);
    upd_req = 1'b1; step(); run(30);

    // R11 sync restarts the counter
    tag = "R11";
    run(5);
    sync_in = 1'b1; step();
    check("R11", count, 0);
    run(20);
    wr(0, 0); run(3);
    sync_in = 1'b1; step();
    check("R11", count, 0);
    run(20);

    // random mix of writes, modes and strobes
    tag = "R10";
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 12) begin
        int a = $urandom_range(0, 5);
        wr_en = 1'b1; wr_addr = 3'(a);
        wr_data = (a == 0) ? 16'($urandom_range(0, 127)) :
                  (a < 4)  ? 16'($urandom_range(0, 20)) : 16'($urandom_range(0, 4095));
      end
      if (r > 97) sync_in = 1'b1;
      if (r > 90 && r < 95) upd_req = 1'b1;
      step();
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule